// File: doc/BRIEF.md
# Out-of-Band Idle-Gap Signal Detector

This block recognises the out-of-band wake and initialisation patterns of a serial storage link before any dword alignment exists. Its only data input is a per-clock flag from an analog squelch front end that says whether burst energy is present on the line. The block measures each electrical-idle stretch between two accepted bursts and classifies it against two time windows. When enough consecutive gaps of one class have been seen, it raises a one-cycle detection pulse.

The time windows are given in nanoseconds and turned into cycle counts from the clock-period parameter `CLK_NS`. With the default 4 ns clock the wake window is 14..43 idle cycles and the initialisation window is 44..131 idle cycles. Bursts shorter than `MIN_BURST` samples are treated as noise. The initialisation pattern looks the same in both link directions, so a parameter chooses which output reports it. A host-side instance (`IS_HOST=1`) reports it as a device-initiated init. A device-side instance reports it as a host reset. All pins are plain level or pulse control signals and take no back-pressure, so the block has no valid/ready interface.

Top module: `oob_gap_classifier`

## Requirements
- R1: A gap is wake-class when its length in low cycles lies in ceil(55/CLK_NS)..floor(175/CLK_NS), which is 14..43 at the defaults.
- R2: A gap is init-class when its length lies in floor(175/CLK_NS)+1..floor(525/CLK_NS), which is 44..131 at the defaults.
- R3: A burst is accepted at the clock edge where the line has been sampled high for `MIN_BURST` (default 4) consecutive edges. When an accepted burst completes `GAPS_NEEDED` (default 3) consecutive same-class gaps, that is four bursts, the matching output is high for the cycle after that edge.
- R4: Every detection pulse lasts exactly one cycle. After a pulse the count and the arming both clear, so a six-burst pattern yields exactly one pulse.
- R5: A gap that falls in neither window resets the gap count. The burst that ends it still counts as the start of a new measurement.
- R6: A gap of the other class restarts the count at one, for the new class.
- R7: A high run shorter than `MIN_BURST` cycles is noise. It neither ends the gap nor adds to the gap length, because only low cycles are counted.
- R8: An idle stretch of floor(525/CLK_NS)+1 low cycles (132 at the defaults) clears the count and the arming. The next burst only starts a new measurement.
- R9: With IS_HOST=1 the init pattern pulses `init_det` and `reset_det` stays low. With IS_HOST=0 it pulses `reset_det` and `init_det` stays low. `wake_det` is the same for both.
- R10: While reset is asserted and in the first cycle after it, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, period CLK_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| line_high | input | 1 | 1 = burst energy present, 0 = electrical idle |
| wake_det | output | 1 | One-cycle pulse on a detected wake pattern |
| init_det | output | 1 | One-cycle pulse on an init pattern (host-side instance) |
| reset_det | output | 1 | One-cycle pulse on an init pattern (device-side instance) |

## Verification
The classifier is driven with four-burst and six-burst trains whose gaps sit in the middle of each window and exactly on each window edge (13, 14, 43, 44, 131, 132 cycles). These trains separate the two classes and expose off-by-one errors at the thresholds. Mixed trains check two other behaviours. Trains with one out-of-window gap show that the count resets. Trains that switch class part-way show that the count restarts for the new class. Gaps with short high glitches inside check that noise is filtered and not counted. A long idle inside a train checks that the negation timeout disarms the measurement. Host-side and device-side instances run in parallel, which shows that the parameter changes only which output reports the init pattern.

// File: rtl/oob_det_pkg.sv
package oob_det_pkg;
  typedef enum logic [1:0] {
    GAP_NONE = 2'd0,
    GAP_WAKE = 2'd1,
    GAP_INIT = 2'd2
  } gap_class_e;
endpackage

// File: rtl/oob_burst_tracker.sv
// Qualifies bursts against a minimum length and measures the low time between them.
module oob_burst_tracker #(
  parameter int MIN_BURST = 4,
  parameter int IDLE_SAT  = 132,
  parameter int IDLE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_high,
  output logic              burst_evt,
  output logic [IDLE_W-1:0] gap_len,
  output logic              idle_timeout
);
  localparam int RW = (MIN_BURST < 2) ? 1 : $clog2(MIN_BURST + 1);

  logic              in_burst;
  logic [RW-1:0]     run;
  logic [IDLE_W-1:0] idle_cnt;

  assign burst_evt    = line_high && !in_burst && (run == RW'(MIN_BURST - 1));
  assign idle_timeout = !line_high && (idle_cnt == IDLE_W'(IDLE_SAT - 1));
  assign gap_len      = idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_burst <= 1'b0;
      run      <= '0;
      idle_cnt <= '0;
    end else if (line_high) begin
      if (!in_burst) begin
        if (burst_evt) begin
          in_burst <= 1'b1;
          run      <= '0;
          idle_cnt <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end else begin
      in_burst <= 1'b0;
      run      <= '0;
      if (idle_cnt != IDLE_W'(IDLE_SAT)) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R7: a burst is only entered after the line was high at the qualifying edge
  a_r7_burst_needs_energy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_burst) |-> ($past(line_high) && $past(run) == RW'(MIN_BURST - 1)));
  // R8: idle counter never runs past its saturation value
  a_r8_idle_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= IDLE_W'(IDLE_SAT));
endmodule

// File: rtl/oob_gap_window.sv
// Sorts a measured gap length into the wake window, the init window or neither.
module oob_gap_window
  import oob_det_pkg::*;
#(
  parameter int IDLE_W   = 8,
  parameter int WAKE_LO  = 14,
  parameter int WAKE_HI  = 43,
  parameter int INIT_LO  = 44,
  parameter int INIT_HI  = 131
) (
  input  logic [IDLE_W-1:0] gap_len,
  output gap_class_e        gap_cls
);
  always_comb begin
    if (gap_len >= IDLE_W'(WAKE_LO) && gap_len <= IDLE_W'(WAKE_HI))
      gap_cls = GAP_WAKE;
    else if (gap_len >= IDLE_W'(INIT_LO) && gap_len <= IDLE_W'(INIT_HI))
      gap_cls = GAP_INIT;
    else
      gap_cls = GAP_NONE;
  end
endmodule

// File: rtl/oob_seq_counter.sv
// Counts consecutive same-class gaps and fires a single-cycle hit.
module oob_seq_counter
  import oob_det_pkg::*;
#(
  parameter int GAPS_NEEDED = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       burst_evt,
  input  gap_class_e gap_cls,
  input  logic       idle_timeout,
  output logic       wake_hit,
  output logic       init_hit
);
  localparam int CW = $clog2(GAPS_NEEDED + 1);

  logic          armed;
  logic [CW-1:0] cnt;
  gap_class_e    cur_cls;
  logic [CW-1:0] cnt_next;

  always_comb begin
    if (cnt != '0 && gap_cls == cur_cls) cnt_next = cnt + 1'b1;
    else                                 cnt_next = CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      cnt      <= '0;
      cur_cls  <= GAP_NONE;
      wake_hit <= 1'b0;
      init_hit <= 1'b0;
    end else begin
      wake_hit <= 1'b0;
      init_hit <= 1'b0;
      if (idle_timeout) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (burst_evt) begin
        if (!armed) begin
          armed <= 1'b1;
          cnt   <= '0;
        end else if (gap_cls == GAP_NONE) begin
          cnt <= '0;
        end else if (cnt_next == CW'(GAPS_NEEDED)) begin
          wake_hit <= (gap_cls == GAP_WAKE);
          init_hit <= (gap_cls == GAP_INIT);
          cnt      <= '0;
          armed    <= 1'b0;
        end else begin
          cnt     <= cnt_next;
          cur_cls <= gap_cls;
        end
      end
    end
  end

  // R3: a hit is only produced after an accepted burst
  a_r3_hit_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit || init_hit) |-> $past(burst_evt));
  // R4: hits are single-cycle and never both at once
  a_r4_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> !wake_hit);
  a_r4_init_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    init_hit |=> !init_hit);
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_hit, init_hit}));
  // R8: negation timeout disarms and clears
  a_r8_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    idle_timeout |=> (cnt == '0 && !armed));
  // R5: an out-of-window gap clears the count
  a_r5_bad_gap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_evt && armed && gap_cls == GAP_NONE) |=> cnt == '0);
endmodule

// File: rtl/oob_gap_classifier.sv
module oob_gap_classifier
  import oob_det_pkg::*;
#(
  parameter int CLK_NS      = 4,
  parameter int WAKE_MIN_NS = 55,
  parameter int SPLIT_NS    = 175,
  parameter int INIT_MAX_NS = 525,
  parameter int MIN_BURST   = 4,
  parameter int GAPS_NEEDED = 3,
  parameter bit IS_HOST     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_high,
  output logic wake_det,
  output logic init_det,
  output logic reset_det
);
  localparam int WAKE_LO  = (WAKE_MIN_NS + CLK_NS - 1) / CLK_NS;
  localparam int WAKE_HI  = SPLIT_NS / CLK_NS;
  localparam int INIT_LO  = WAKE_HI + 1;
  localparam int INIT_HI  = INIT_MAX_NS / CLK_NS;
  localparam int IDLE_SAT = INIT_HI + 1;
  localparam int IDLE_W   = $clog2(IDLE_SAT + 1);

  logic              burst_evt;
  logic              idle_timeout;
  logic [IDLE_W-1:0] gap_len;
  gap_class_e        gap_cls;
  logic              init_hit;

  oob_burst_tracker #(
    .MIN_BURST (MIN_BURST),
    .IDLE_SAT  (IDLE_SAT),
    .IDLE_W    (IDLE_W)
  ) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_high    (line_high),
    .burst_evt    (burst_evt),
    .gap_len      (gap_len),
    .idle_timeout (idle_timeout)
  );

  oob_gap_window #(
    .IDLE_W  (IDLE_W),
    .WAKE_LO (WAKE_LO),
    .WAKE_HI (WAKE_HI),
    .INIT_LO (INIT_LO),
    .INIT_HI (INIT_HI)
  ) u_window (
    .gap_len (gap_len),
    .gap_cls (gap_cls)
  );

  oob_seq_counter #(
    .GAPS_NEEDED (GAPS_NEEDED)
  ) u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_evt    (burst_evt),
    .gap_cls      (gap_cls),
    .idle_timeout (idle_timeout),
    .wake_hit     (wake_det),
    .init_hit     (init_hit)
  );

  generate
    if (IS_HOST) begin : g_host
      assign init_det  = init_hit;
      assign reset_det = 1'b0;
    end else begin : g_device
      assign init_det  = 1'b0;
      assign reset_det = init_hit;
    end
  endgenerate

  // R10: outputs quiet in the cycle after reset
  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !(wake_det || init_det || reset_det));
  // R9: the two init reporting pins never pulse together
  a_r9_single_init_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_det && reset_det));
endmodule

// File: tb/oob_gap_classifier_test.sv
`timescale 1ns/1ps
module oob_gap_classifier_test;
  localparam int MINB = 4;
  localparam int BL   = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic h_wake, h_init, h_reset, d_wake, d_init, d_reset;

  always #2 clk = ~clk;

  oob_gap_classifier #(.IS_HOST(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .line_high(line),
    .wake_det(h_wake), .init_det(h_init), .reset_det(h_reset));

  oob_gap_classifier #(.IS_HOST(1'b0)) uut_dev (
    .clk(clk), .rst_n(rst_n), .line_high(line),
    .wake_det(d_wake), .init_det(d_init), .reset_det(d_reset));

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R10";
  bit done = 0;

  // behavioural reference: gap classes kept in a queue
  int m_idle, m_hi;
  bit m_inb, m_armed;
  int q[$];
  bit e_wake, e_init;

  function automatic int classify(int g);
    if (g >= 14 && g <= 43) return 1;
    if (g >= 44 && g <= 131) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    e_wake = 0;
    e_init = 0;
    if (!rst_n) begin
      m_idle = 0; m_hi = 0; m_inb = 0; m_armed = 0; q.delete();
    end else if (line) begin
      if (!m_inb) begin
        m_hi++;
        if (m_hi == MINB) begin
          m_inb = 1; m_hi = 0;
          if (!m_armed) begin
            m_armed = 1; q.delete();
          end else begin
            int c;
            c = classify(m_idle);
            if (c == 0) q.delete();
            else begin
              if (q.size() != 0 && q[$] != c) q.delete();
              q.push_back(c);
              if (q.size() == 3) begin
                if (c == 1) e_wake = 1; else e_init = 1;
                q.delete(); m_armed = 0;
              end
            end
          end
          m_idle = 0;
        end
      end
    end else begin
      m_inb = 0; m_hi = 0;
      if (m_idle < 132) begin
        m_idle++;
        if (m_idle == 132) begin m_armed = 0; q.delete(); end
      end
    end
  end

  int n_wake, n_init, n_reset;

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("host wake", h_wake, e_wake);
      cmp("host init", h_init, e_init);
      cmp("host reset", h_reset, 0);
      cmp("dev wake", d_wake, e_wake);
      cmp("dev init", d_init, 0);
      cmp("dev reset", d_reset, e_init);
      n_wake  += h_wake;
      n_init  += h_init;
      n_reset += d_reset;
    end
  end

  task automatic drive(bit v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line = v;
    end
  endtask

  task automatic train(int g1, int g2, int g3);
    drive(1, BL); drive(0, g1);
    drive(1, BL); drive(0, g2);
    drive(1, BL); drive(0, g3);
    drive(1, BL); drive(0, 2);
  endtask

  task automatic start(string req);
    drive(0, 140);
    cur_req = req;
    n_wake = 0; n_init = 0; n_reset = 0;
  endtask

  task automatic tally(int w, int i);
    drive(0, 3);
    cmp("wake pulses", n_wake, w);
    cmp("init pulses", n_init, i);
    cmp("reset pulses (device)", n_reset, i);
  endtask

  initial begin
    n_wake = 0; n_init = 0; n_reset = 0;
    // R10: reset state
    repeat (3) @(negedge clk);
    cmp("R10 wake in reset", h_wake, 0);
    cmp("R10 init in reset", h_init, 0);
    rst_n = 1'b1;
    drive(0, 2);
    cmp("R10 outputs after reset", h_wake | h_init | d_reset, 0);

    start("R1");  train(30, 30, 30);    tally(1, 0);
    start("R1");  train(14, 14, 14);    tally(1, 0);
    start("R1");  train(43, 43, 43);    tally(1, 0);
    start("R2");  train(100, 100, 100); tally(0, 1);
    start("R2");  train(44, 44, 44);    tally(0, 1);
    start("R2");  train(131, 131, 131); tally(0, 1);
    start("R5");  train(13, 13, 13);    tally(0, 0);
    start("R5");  train(30, 10, 30);    tally(0, 0);
    start("R4");  // six bursts give one pulse
    train(30, 30, 30); drive(0, 28); drive(1, BL); drive(0, 30); drive(1, BL);
    tally(1, 0);
    start("R6");  // wake, wake, then three init gaps
    drive(1, BL); drive(0, 30); drive(1, BL); drive(0, 30);
    train(100, 100, 100);
    tally(0, 1);
    start("R7");  // gaps: 15 low, 3 high glitch, 15 low
    for (int b = 0; b < 3; b++) begin
      drive(1, BL); drive(0, 15); drive(1, MINB - 1); drive(0, 15);
    end
    drive(1, BL);
    tally(1, 0);
    start("R8");  // long idle inside the train
    drive(1, BL); drive(0, 30); drive(1, BL); drive(0, 30);
    drive(1, BL); drive(0, 200); drive(1, BL); drive(0, 30); drive(1, BL);
    tally(0, 0);
    start("R8");  train(132, 132, 132); tally(0, 0);
    start("R9");  train(60, 60, 60);    tally(0, 1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 200000);
    done = 1;
    miscompares++;
    vectors++;
    $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule